// File: doc/BRIEF.md
# Subroutine Call Sequencer with Paged Program Counter

This block runs the subroutine-call instructions of a small 4-bit controller core. The program counter has two parts: a 4-bit page and an 8-bit step. The fetch logic raises `start_i` for one cycle and presents the following values:

- the 12-bit instruction word;
- the current page and step;
- the pending-page value;
- the 8-bit stack pointer.

The sequencer latches all of these on that cycle and raises `busy_o`. Over a fixed window it pushes the return address to nibble-wide data memory, one nibble per cycle, through a simple write port.

It then presents the new page, the new step and the new stack pointer. At the same time it raises `done_o` for one cycle. There are two call forms. A paged call takes its target page from the pending-page register. A page-zero call forces the target page to zero. In both forms the 8-bit operand becomes the new step.

Any opcode that is not a call runs through the same window. It writes nothing to memory, and the outputs return the latched page, step and stack pointer unchanged.

Top module: `call_seq`

## Requirements
- R1: Instruction bits [11:8] = 4'b0100 select a paged call, and 4'b0101 selects a page-zero call. Bits [7:0] are the step target in both forms.
- R2: A call writes memory in the 2nd, 3rd and 4th busy cycles, one write in each:
  - the page goes to SP-1;
  - step bits [7:4] go to SP-2;
  - (step bits [3:0] + 1) mod 16 goes to SP-3, with no carry into the high nibble.
- R3: All stack addresses wrap modulo 256, and after a call `sp_o` equals (SP - 3) mod 256.
- R4: After a paged call `page_o` equals the latched pending page. After a page-zero call `page_o` is 0.
- R5: After either call `step_o` equals the instruction's bits [7:0].
- R6: `busy_o` is high for exactly 7 cycles, starting the cycle after `start_i` is sampled. `done_o` is high only in the 7th of those cycles. From that cycle on, `page_o`, `step_o` and `sp_o` hold the result until the next completion.
- R7: A `start_i` pulse while `busy_o` is high has no effect on the running operation, its writes or its results.
- R8: An opcode that is neither call form completes in the same 7 cycles with no memory write. `page_o`, `step_o` and `sp_o` then equal the latched page, step and SP.
- R9: `mem_we_o` is never high outside `busy_o`, and at most one nibble is written per cycle.
- R10: After reset `busy_o`, `done_o` and `mem_we_o` are 0, and `page_o`, `step_o` and `sp_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request; latches all operands |
| instr_i | input | 12 | Instruction word |
| page_i | input | 4 | Current page |
| step_i | input | 8 | Current step |
| pend_page_i | input | 4 | Pending page for paged calls |
| sp_i | input | 8 | Current stack pointer |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion, results valid |
| mem_we_o | output | 1 | Data memory write enable |
| mem_addr_o | output | 8 | Data memory write address |
| mem_wdata_o | output | 4 | Data memory write nibble |
| page_o | output | 4 | Resulting page |
| step_o | output | 8 | Resulting step |
| sp_o | output | 8 | Resulting stack pointer |

## Verification
The hardest cases to reach from the ports are the address and nibble wrap-arounds. These occur when SP is 0, 1 or 2 and when the low step nibble is F. The stimulus forces them with directed calls and also biases the random SP and step values toward those edges.

A start pulse that lands inside a running window is also hard to produce by chance. The bench injects such a pulse, carrying unrelated operands, on a random busy cycle of many calls. It then confirms that the writes and results still match the first request.

// File: rtl/call_seq_pkg.sv
package call_seq_pkg;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned PAGE_W  = 4;
  localparam int unsigned STEP_W  = 8;
  localparam int unsigned SP_W    = 8;
  localparam int unsigned INSTR_W = 12;
  localparam int unsigned N_PUSH  = 3;

  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_PAGED = 2'd1,
    CK_ZERO  = 2'd2
  } call_kind_e;

  localparam logic [3:0] OP_PAGED = 4'b0100;
  localparam logic [3:0] OP_ZERO  = 4'b0101;
endpackage

// File: rtl/call_seq_decode.sv
module call_seq_decode
  import call_seq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output call_kind_e         kind_o,
  output logic [STEP_W-1:0]  target_o
);
  logic [3:0] op;
  assign op       = instr_i[INSTR_W-1 -: 4];
  assign target_o = instr_i[STEP_W-1:0];

  always_comb begin
    unique case (op)
      OP_PAGED: kind_o = CK_PAGED;
      OP_ZERO:  kind_o = CK_ZERO;
      default:  kind_o = CK_NONE;
    endcase
  end
endmodule

// File: rtl/call_seq_timer.sv
module call_seq_timer #(
  parameter int unsigned CYCLES     = 7,
  parameter int unsigned PUSH_FIRST = 1,
  parameter int unsigned N_PUSH     = 3,
  localparam int unsigned CNT_W     = $clog2(CYCLES),
  localparam int unsigned SLOT_W    = (N_PUSH > 1) ? $clog2(N_PUSH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              load_res_o,
  output logic              push_act_o,
  output logic [SLOT_W-1:0] push_slot_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 2);
  localparam logic [CNT_W-1:0] P_LO = CNT_W'(PUSH_FIRST);
  localparam logic [CNT_W-1:0] P_HI = CNT_W'(PUSH_FIRST + N_PUSH - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rel;

  assign accept_o = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rel         = cnt_q - P_LO;
  assign busy_o      = busy_q;
  assign done_o      = busy_q && (cnt_q == LAST);
  assign load_res_o  = busy_q && (cnt_q == LOAD);
  assign push_act_o  = busy_q && (cnt_q >= P_LO) && (cnt_q <= P_HI);
  assign push_slot_o = rel[SLOT_W-1:0];
endmodule

// File: rtl/call_seq_push.sv
module call_seq_push
  import call_seq_pkg::*;
#(
  localparam int unsigned SLOT_W = $clog2(N_PUSH)
) (
  input  logic              push_act_i,
  input  logic [SLOT_W-1:0] push_slot_i,
  input  logic              is_call_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [SP_W-1:0]   sp_i,
  output logic              we_o,
  output logic [SP_W-1:0]   addr_o,
  output logic [NIB_W-1:0]  wdata_o
);
  // slot 0 -> SP-1 page, slot 1 -> SP-2 step high, slot 2 -> SP-3 step low + 1
  logic [NIB_W-1:0] nib [N_PUSH];
  assign nib[0] = page_i;
  assign nib[1] = step_i[STEP_W-1 -: NIB_W];
  assign nib[2] = step_i[NIB_W-1:0] + 1'b1;

  assign we_o    = push_act_i & is_call_i;
  assign addr_o  = sp_i - SP_W'(push_slot_i) - 1'b1;
  assign wdata_o = (32'(push_slot_i) < N_PUSH) ? nib[push_slot_i] : '0;
endmodule

// File: rtl/call_seq.sv
module call_seq
  import call_seq_pkg::*;
#(
  parameter int unsigned CYCLES     = 7,
  parameter int unsigned PUSH_FIRST = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [PAGE_W-1:0]  page_i,
  input  logic [STEP_W-1:0]  step_i,
  input  logic [PAGE_W-1:0]  pend_page_i,
  input  logic [SP_W-1:0]    sp_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               mem_we_o,
  output logic [SP_W-1:0]    mem_addr_o,
  output logic [NIB_W-1:0]   mem_wdata_o,
  output logic [PAGE_W-1:0]  page_o,
  output logic [STEP_W-1:0]  step_o,
  output logic [SP_W-1:0]    sp_o
);
  localparam int unsigned SLOT_W = $clog2(N_PUSH);

  logic              accept, load_res, push_act;
  logic [SLOT_W-1:0] push_slot;
  call_kind_e        kind_d, kind_q;
  logic [STEP_W-1:0] target_d, target_q;
  logic [PAGE_W-1:0] page_q, pend_q;
  logic [STEP_W-1:0] step_q;
  logic [SP_W-1:0]   sp_q;
  logic              is_call_q;
  logic [PAGE_W-1:0] page_r;
  logic [STEP_W-1:0] step_r;
  logic [SP_W-1:0]   sp_r;

  call_seq_decode u_dec (
    .instr_i (instr_i),
    .kind_o  (kind_d),
    .target_o(target_d)
  );

  call_seq_timer #(
    .CYCLES    (CYCLES),
    .PUSH_FIRST(PUSH_FIRST),
    .N_PUSH    (N_PUSH)
  ) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .accept_o   (accept),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .load_res_o (load_res),
    .push_act_o (push_act),
    .push_slot_o(push_slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q    <= CK_NONE;
      target_q  <= '0;
      page_q    <= '0;
      pend_q    <= '0;
      step_q    <= '0;
      sp_q      <= '0;
      is_call_q <= 1'b0;
    end else if (accept) begin
      kind_q    <= kind_d;
      target_q  <= target_d;
      page_q    <= page_i;
      pend_q    <= pend_page_i;
      step_q    <= step_i;
      sp_q      <= sp_i;
      is_call_q <= (kind_d != CK_NONE);
    end
  end

  call_seq_push u_push (
    .push_act_i (push_act),
    .push_slot_i(push_slot),
    .is_call_i  (is_call_q),
    .page_i     (page_q),
    .step_i     (step_q),
    .sp_i       (sp_q),
    .we_o       (mem_we_o),
    .addr_o     (mem_addr_o),
    .wdata_o    (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_r <= '0;
      step_r <= '0;
      sp_r   <= '0;
    end else if (load_res) begin
      unique case (kind_q)
        CK_PAGED: begin
          page_r <= pend_q;
          step_r <= target_q;
          sp_r   <= sp_q - SP_W'(N_PUSH);
        end
        CK_ZERO: begin
          page_r <= '0;
          step_r <= target_q;
          sp_r   <= sp_q - SP_W'(N_PUSH);
        end
        default: begin
          page_r <= page_q;
          step_r <= step_q;
          sp_r   <= sp_q;
        end
      endcase
    end
  end

  assign page_o = page_r;
  assign step_o = step_r;
  assign sp_o   = sp_r;
endmodule

// File: rtl/call_seq_chk.sv
module call_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       mem_we_o,
  input logic [7:0] sp_o,
  input logic [7:0] sp_q,
  input logic       is_call_q
);
  assert_we_in_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  assert_done_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  assert_done_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  assert_busy_from_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  assert_sp_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_call_q) |-> (sp_o == sp_q - 8'd3));
  assert_restart_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> (busy_o && $stable(sp_q)));
  assert_noncall_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> is_call_q);
endmodule

bind call_seq call_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .mem_we_o (mem_we_o),
  .sp_o     (sp_o),
  .sp_q     (sp_q),
  .is_call_q(is_call_q)
);

// File: tb/call_seq_tb.sv
`timescale 1ns/1ps
module call_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] instr_i = '0;
  logic [3:0]  page_i = '0, pend_page_i = '0;
  logic [7:0]  step_i = '0, sp_i = '0;
  logic        busy_o, done_o, mem_we_o;
  logic [7:0]  mem_addr_o;
  logic [3:0]  mem_wdata_o;
  logic [3:0]  page_o;
  logic [7:0]  step_o, sp_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [3:0] mem [256];

  always #2.5 clk_i = ~clk_i;

  call_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .instr_i(instr_i),
    .page_i(page_i), .step_i(step_i), .pend_page_i(pend_page_i), .sp_i(sp_i),
    .busy_o(busy_o), .done_o(done_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .page_o(page_o), .step_o(step_o), .sp_o(sp_o)
  );

  always @(posedge clk_i) if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [11:0] ins);
    if (ins[11:8] == 4'b0100) return 1;
    if (ins[11:8] == 4'b0101) return 2;
    return 0;
  endfunction

  function automatic logic [3:0] exp_nib(input int k, input logic [3:0] pg, input logic [7:0] st);
    case (k)
      0: return pg;
      1: return st[7:4];
      default: return st[3:0] + 4'd1;
    endcase
  endfunction

  // one full operation; inj>0 injects a start pulse on busy cycle inj
  task automatic run_call(input logic [11:0] ins, input logic [3:0] pg, input logic [7:0] st,
                          input logic [3:0] pp, input logic [7:0] sp, input int inj);
    int kd;
    logic [3:0] ep;
    logic [7:0] es, esp;
    kd = kind_of(ins);
    @(negedge clk_i);
    start_i = 1'b1; instr_i = ins; page_i = pg; step_i = st; pend_page_i = pp; sp_i = sp;
    @(negedge clk_i);
    start_i = 1'b0;
    instr_i = 12'($urandom); page_i = 4'($urandom); step_i = 8'($urandom);
    pend_page_i = 4'($urandom); sp_i = 8'($urandom);
    for (int k = 1; k <= 7; k++) begin
      chk("R6", "busy", busy_o, 1);
      chk("R6", "done", done_o, (k == 7));
      if (kd != 0 && k >= 2 && k <= 4) begin
        chk("R2", "we", mem_we_o, 1);
        chk("R3", "addr", mem_addr_o, 8'(sp - 8'(k - 1)));
        chk("R2", "data", mem_wdata_o, exp_nib(k - 2, pg, st));
      end else begin
        chk((kd == 0) ? "R8" : "R9", "we idle", mem_we_o, 0);
      end
      if (k == 7) begin
        if (kd == 0) begin ep = pg; es = st; esp = sp; end
        else begin
          ep = (kd == 1) ? pp : 4'd0;
          es = ins[7:0];
          esp = sp - 8'd3;
        end
        chk((kd == 0) ? "R8" : "R4", "page", page_o, ep);
        chk((kd == 0) ? "R8" : "R5", "step", step_o, es);
        chk((kd == 0) ? "R8" : "R3", "sp", sp_o, esp);
      end
      start_i = (k == inj);  // R7: restart attempt while busy
      @(negedge clk_i);
      start_i = 1'b0;
    end
    chk("R6", "busy after", busy_o, 0);
    chk("R9", "we after", mem_we_o, 0);
    chk("R6", "hold page", page_o, (kd == 0) ? pg : ((kd == 1) ? pp : 4'd0));
  endtask

  initial begin
    void'($urandom(32'hC0FFEE));
    for (int i = 0; i < 256; i++) mem[i] = 4'h0;
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10", "busy", busy_o, 0);
    chk("R10", "done", done_o, 0);
    chk("R10", "we", mem_we_o, 0);
    chk("R10", "page", page_o, 0);
    chk("R10", "step", step_o, 0);
    chk("R10", "sp", sp_o, 0);

    // R1 R2 worked example: paged call
    run_call(12'h410, 4'h3, 8'h2C, 4'h1, 8'hC0, 0);
    chk("R2", "mem BF", mem[8'hBF], 4'h3);
    chk("R2", "mem BE", mem[8'hBE], 4'h2);
    chk("R2", "mem BD", mem[8'hBD], 4'hD);
    // R4 page-zero
    run_call(12'h510, 4'hA, 8'h2E, 4'h7, 8'hCA, 0);
    // R2 low nibble wrap, R3 address wrap
    run_call(12'h4FF, 4'hF, 8'h9F, 4'h5, 8'h01, 0);
    chk("R2", "wrap nib", mem[8'hFE], 4'h0);
    chk("R2", "no carry", mem[8'hFF], 4'h9);
    run_call(12'h500, 4'h2, 8'hFF, 4'h0, 8'h00, 0);
    run_call(12'h4AB, 4'h6, 8'h0F, 4'hE, 8'h02, 0);
    // R8 non-call: memory untouched
    mem[8'h7F] = 4'h5;
    run_call(12'h6AB, 4'h4, 8'h5A, 4'h9, 8'h80, 0);
    chk("R8", "mem untouched", mem[8'h7F], 4'h5);
    run_call(12'hFFF, 4'h1, 8'h11, 4'h2, 8'h33, 3);
    // R7 restart during busy
    run_call(12'h420, 4'h8, 8'h44, 4'hB, 8'h50, 2);
    run_call(12'h530, 4'h8, 8'h44, 4'hB, 8'h50, 7);

    for (int n = 0; n < 300; n++) begin
      logic [11:0] ins;
      logic [7:0]  sp, st;
      int sel;
      sel = $urandom_range(0, 3);
      ins = {(sel == 0) ? 4'($urandom) : ((sel == 1) ? 4'h4 : 4'h5), 8'($urandom)};
      sp  = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 2)) : 8'($urandom);
      st  = ($urandom_range(0, 3) == 0) ? {4'($urandom), 4'hF} : 8'($urandom);
      run_call(ins, 4'($urandom), st, 4'($urandom), sp, $urandom_range(0, 7));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule